// File: doc/BRIEF.md
# Configurable-Type Register Byte

This block holds eight interface register bits that a bus slave controller reaches as one byte. The controller gives a single read enable and a single write enable for the whole byte, and the byte occupies a fixed lane of a 32-bit data bus. The lane is the byte's address modulo four. Address decoding and protocol timing stay in the controller. The user logic attached to each bit stays outside the block.

Each bit has a static 3-bit type selector, so one bit can behave in any of these ways:
- a plain read/write flop;
- a value that user logic supplies and the bus can only read;
- an interrupt-style flag that an event sets and the master clears by writing 1;
- a request flag that the master raises and user logic acknowledges;
- a trigger that sends a single-cycle strobe to user logic.

Each bit also has a user-side input and a user-side output. Through these the surrounding design can set the bit, watch it or be woken by it.

Top module: `cfg_reg_byte`

## Requirements
- R1: After reset every stored bit is 0. Every `usr_out` bit is 0, and a read returns 0 for every bit whose type is not read-only.
- R2: The byte uses lane L = BYTE_OFFSET mod 4, which is `rdata`/`wdata` bits [8L+7:8L]. Write data on other lanes is ignored. `rdata` is 0 outside lane L, and all of `rdata` is 0 when `rd_en` is low.
- R3: Type code 0 (read/write), with bit i's code at `bit_type[3i+2:3i]`: a write stores the lane bit, a read returns the stored bit, and `usr_out[i]` shows the stored bit.
- R4: Type code 1 (read-only): a read returns `usr_in[i]` in the same cycle. Writes have no effect, and `usr_out[i]` is 0.
- R5: Type code 2 (write-1-to-clear): `usr_in[i]` high sets the bit. A write of 1 clears it, and a write of 0 leaves it unchanged. Reads and `usr_out[i]` show the bit.
- R6: For type code 2, a set event in the same cycle as a clearing write wins, so the bit stays 1.
- R7: Type code 3 (sticky handshake): a write of 1 sets the bit, and a write of 0 has no effect. `usr_in[i]` high clears it (acknowledge), but a set in the same cycle wins. Reads and `usr_out[i]` show the bit.
- R8: Type code 4 (trigger): a write of 1 drives `usr_out[i]` high for exactly the one cycle after the write edge. The bit always reads 0.
- R9: Type codes 5 to 7 are inert: the bit reads 0, `usr_out[i]` stays 0, and writes have no effect.
- R10: All eight bits update together on one clock edge with `wr_en` high. With `wr_en` low no bit changes in response to `wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write enable from the bus controller |
| rd_en | input | 1 | Byte read enable from the bus controller |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data, only this byte's lane non-zero |
| bit_type | input | 24 | Static 3-bit type code per bit |
| usr_in | input | 8 | User-side input per bit (value, set, or acknowledge) |
| usr_out | output | 8 | User-side output per bit (state or strobe) |

## Verification
A random phase uses a fixed seed and runs two type layouts. The first mixes every code across the eight bits, and the second makes all bits read/write. The random stimulus draws enables, write data and user inputs, so writes of 0 and 1 meet set and acknowledge events in every combination. Directed cases then isolate the situations that random traffic may reach only rarely:
- a write-1-to-clear bit where the set event and the clearing write arrive together;
- a handshake bit with its set and acknowledge in the same cycle;
- the strobe lasting exactly one cycle;
- writes that carry all ones on the foreign lanes;
- data presented while `wr_en` is low.

Each of these separates a correct priority or lane choice from a plausible wrong one.

// File: rtl/cfg_reg_pkg.sv
package cfg_reg_pkg;
  localparam int KIND_W = 3;
  localparam logic [KIND_W-1:0] K_RW   = 3'd0;
  localparam logic [KIND_W-1:0] K_RO   = 3'd1;
  localparam logic [KIND_W-1:0] K_W1C  = 3'd2;
  localparam logic [KIND_W-1:0] K_RWS  = 3'd3;
  localparam logic [KIND_W-1:0] K_TRIG = 3'd4;

  // next stored value of one bit
  function automatic logic cell_next(input logic [KIND_W-1:0] kind, input logic q,
                                     input logic wr, input logic wbit, input logic usr);
    logic nxt;
    case (kind)
      K_RW:    nxt = wr ? wbit : q;
      K_W1C:   nxt = usr | (q & ~(wr & wbit));
      K_RWS:   nxt = (wr & wbit) | (q & ~usr);
      K_TRIG:  nxt = wr & wbit;
      default: nxt = 1'b0;
    endcase
    return nxt;
  endfunction

  // value presented to the bus on a read
  function automatic logic cell_read(input logic [KIND_W-1:0] kind, input logic q,
                                     input logic usr);
    logic v;
    case (kind)
      K_RW, K_W1C, K_RWS: v = q;
      K_RO:               v = usr;
      default:            v = 1'b0;
    endcase
    return v;
  endfunction

  // value presented to user logic
  function automatic logic cell_user(input logic [KIND_W-1:0] kind, input logic q);
    logic v;
    case (kind)
      K_RW, K_W1C, K_RWS, K_TRIG: v = q;
      default:                    v = 1'b0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/cfg_reg_cell.sv
module cfg_reg_cell
  import cfg_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_bit,
  input  logic              usr_in,
  input  logic [KIND_W-1:0] kind,
  output logic              rd_bit,
  output logic              usr_out
);
  logic q;
  logic set_evt;
  logic clr_wr;

  assign set_evt = wr_en & wr_bit;
  assign clr_wr  = wr_en & wr_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= cell_next(kind, q, wr_en, wr_bit, usr_in);
  end

  assign rd_bit  = cell_read(kind, q, usr_in);
  assign usr_out = cell_user(kind, q);

  AST_RW_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_RW && wr_en) |=> (rd_bit == $past(wr_bit))); // R3
  AST_W1C_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_W1C && usr_in) |=> rd_bit); // R6
  AST_W1C_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_W1C && rd_bit && !clr_wr) |=> rd_bit); // R5
  AST_RWS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_RWS && rd_bit && !usr_in) |=> rd_bit); // R7
  AST_RWS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_RWS && set_evt) |=> usr_out); // R7
  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_TRIG && usr_out && !set_evt) |=> !usr_out); // R8
  AST_TRIG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_TRIG) |-> !rd_bit); // R8
  AST_INERT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (kind > K_TRIG) |-> (!rd_bit && !usr_out)); // R9
endmodule

// File: rtl/cfg_reg_lane.sv
module cfg_reg_lane #(
  parameter int BUS_W  = 32,
  parameter int BYTE_W = 8,
  parameter int LANE   = 0
) (
  input  logic [BUS_W-1:0]  wdata,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] wr_byte,
  output logic [BUS_W-1:0]  rdata
);
  localparam int LANES = BUS_W / BYTE_W;

  assign wr_byte = wdata[LANE*BYTE_W +: BYTE_W];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == LANE) begin : g_own
      assign rdata[l*BYTE_W +: BYTE_W] = rd_en ? rd_byte : '0;
    end else begin : g_other
      assign rdata[l*BYTE_W +: BYTE_W] = '0;
    end
  end
endmodule

// File: rtl/cfg_reg_byte.sv
module cfg_reg_byte
  import cfg_reg_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int BYTE_W      = 8,
  parameter int BYTE_OFFSET = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [BUS_W-1:0]         wdata,
  output logic [BUS_W-1:0]         rdata,
  input  logic [BYTE_W*KIND_W-1:0] bit_type,
  input  logic [BYTE_W-1:0]        usr_in,
  output logic [BYTE_W-1:0]        usr_out
);
  localparam int LANES = BUS_W / BYTE_W;
  localparam int LANE  = BYTE_OFFSET % LANES;

  logic [BYTE_W-1:0] wr_byte;
  logic [BYTE_W-1:0] rd_byte;
  logic [BUS_W-1:0]  lane_mask;

  assign lane_mask = {{(BUS_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}} << (LANE*BYTE_W);

  cfg_reg_lane #(.BUS_W(BUS_W), .BYTE_W(BYTE_W), .LANE(LANE)) u_lane (
    .wdata(wdata), .rd_en(rd_en), .rd_byte(rd_byte),
    .wr_byte(wr_byte), .rdata(rdata)
  );

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    cfg_reg_cell u_cell (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_byte[i]),
      .usr_in(usr_in[i]), .kind(bit_type[i*KIND_W +: KIND_W]),
      .rd_bit(rd_byte[i]), .usr_out(usr_out[i])
    );
  end

  AST_FOREIGN_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~lane_mask) == '0); // R2
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0)); // R2
  AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && usr_in == '0) |=> (usr_out & ~$past(usr_out)) == '0); // R10
endmodule

// File: tb/cfg_reg_byte_test.sv
module cfg_reg_byte_test;
  localparam int OFS  = 6;
  localparam int LANE = OFS % 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [23:0] bit_type = '0;
  logic [7:0]  usr_in = '0;
  logic [7:0]  usr_out;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] m;   // model of stored bits

  always #10 clk = ~clk;

  cfg_reg_byte #(.BYTE_OFFSET(OFS)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .bit_type(bit_type), .usr_in(usr_in), .usr_out(usr_out)
  );

  function automatic logic [2:0] kind_of(int i);
    return bit_type[3*i +: 3];
  endfunction

  function automatic string tag(logic [2:0] k);
    case (k)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic exp_rd(int i);
    logic [2:0] k = kind_of(i);
    if (k == 3'd1) return usr_in[i];
    if (k == 3'd0 || k == 3'd2 || k == 3'd3) return m[i];
    return 1'b0;
  endfunction

  function automatic logic exp_usr(int i);
    logic [2:0] k = kind_of(i);
    if (k <= 3'd4 && k != 3'd1) return m[i];
    return 1'b0;
  endfunction

  function automatic logic model_next(int i, logic we, logic wb, logic u);
    case (kind_of(i))
      3'd0: return we ? wb : m[i];
      3'd2: return u ? 1'b1 : ((we && wb) ? 1'b0 : m[i]);
      3'd3: return (we && wb) ? 1'b1 : (u ? 1'b0 : m[i]);
      3'd4: return we && wb;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive after negedge, check comb read and state, advance model
  task automatic step(logic we, logic re, logic [31:0] wd, logic [7:0] ui);
    logic [31:0] er;
    logic [7:0] nm;
    wr_en = we; rd_en = re; wdata = wd; usr_in = ui;
    #1;
    er = '0;
    for (int i = 0; i < 8; i++) begin
      if (re) er[LANE*8+i] = exp_rd(i);
      check(tag(kind_of(i)), {31'd0, rdata[LANE*8+i]}, {31'd0, er[LANE*8+i]});
      check(tag(kind_of(i)), {31'd0, usr_out[i]}, {31'd0, exp_usr(i)});
    end
    check("R2", rdata, er);
    for (int i = 0; i < 8; i++) nm[i] = model_next(i, we, wd[LANE*8+i], ui[i]);
    @(posedge clk);
    m = nm;
    @(negedge clk);
  endtask

  task automatic do_reset(logic [23:0] cfg);
    rst_n = 1'b0; wr_en = 0; rd_en = 0; wdata = '0; usr_in = '0;
    bit_type = cfg; m = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] on_lane(logic [7:0] b);
    return {24'd0, b} << (LANE*8);
  endfunction

  initial begin
    logic [23:0] mix;
    int seed;
    seed = 1234;
    void'($urandom(seed));
    // bits 0..7: RW, RO, W1C, RWS, TRIG, 7, W1C, RWS
    mix = {3'd3, 3'd2, 3'd7, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
    do_reset(mix);
    // R1: reset state
    rd_en = 1; usr_in = '0; #1;
    check("R1", rdata, '0);
    check("R1", {24'd0, usr_out}, '0);

    // R2: foreign lanes all ones, own lane zero -> nothing set
    step(1, 0, ~on_lane(8'hFF), 8'h00);
    step(0, 1, '0, 8'h00);
    check("R2", {24'd0, usr_out}, '0);

    // R10: data with wr_en low changes nothing
    step(0, 0, '1, 8'h00);
    step(0, 1, '0, 8'h00);
    check("R10", {24'd0, usr_out}, '0);
    // R10: one write sets RW and RWS bits together
    step(1, 0, on_lane(8'hFF), 8'h00);
    check("R10", {24'd0, usr_out & 8'b1000_1001}, {24'd0, 8'b1000_1001});

    // R6: W1C bit 2 set, then set + clearing write together
    step(0, 0, '0, 8'h04);
    step(1, 0, on_lane(8'h04), 8'h04);
    check("R6", {31'd0, usr_out[2]}, 32'd1);
    step(1, 0, on_lane(8'h04), 8'h00);   // R5 clear
    check("R5", {31'd0, usr_out[2]}, 32'd0);

    // R7: RWS bit 3 set and ack together -> stays set; ack alone clears
    step(1, 0, on_lane(8'h08), 8'h08);
    check("R7", {31'd0, usr_out[3]}, 32'd1);
    step(0, 0, '0, 8'h08);
    check("R7", {31'd0, usr_out[3]}, 32'd0);

    // R8: trigger strobe lasts one cycle
    step(1, 0, on_lane(8'h10), 8'h00);
    check("R8", {31'd0, usr_out[4]}, 32'd1);
    step(0, 1, '0, 8'h00);
    check("R8", {31'd0, usr_out[4]}, 32'd0);

    // R9: inert bit 5 ignores writes
    step(1, 1, on_lane(8'h20), 8'h20);
    check("R9", {31'd0, usr_out[5]}, 32'd0);

    // random phase, mixed layout
    for (int n = 0; n < 400; n++)
      step(1'($urandom), 1'($urandom), $urandom, 8'($urandom));

    // random phase, all read/write
    do_reset('0);
    for (int n = 0; n < 300; n++)
      step(1'($urandom), 1'($urandom), $urandom, 8'($urandom));

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule